// File: doc/BRIEF.md
# Dual 8-bit Timer with Software-Cleared Status Flags

This block holds two independent up-counters, a low channel and a high channel. Each channel has its own compare register, and a single shared control/status byte covers both. A counter advances by one on each cycle in which its count-enable tick is high. On each tick it checks two events: whether the current count equals its compare value, and whether the count sits at its top value. Each event sets a sticky flag in the status byte. Software can clear a flag only through a two-step handshake: it must first read the status byte while the flag is 1, and then write 0 to that bit. Software has no way to raise a flag.

Each channel also has two control bits in the status byte. The first is an overflow interrupt enable. The second is a clear select, which picks one of two counting modes: the counter wraps freely from its top value to zero, or it restarts at zero on the tick at which it equals its compare value. Each channel drives its own interrupt output. All registers sit behind a small synchronous bus with an address, a write enable, write data, a read strobe and combinational read data.

Top module: `dual_tmr8`

## Requirements
- R1: Reset, which is asserted asynchronously on `rst_n` low, sets the following values: status byte 0x00, both counters 0x00, both compare registers 0xFF, and both interrupt outputs 0.
- R2: The bus address map is: 0 is the status byte, 1 is the high counter, 2 is the high compare register, 3 is the low counter and 4 is the low compare register. A write takes effect on the clock edge that samples it, and `bus_rdata` shows the addressed register combinationally.
- R3: When a channel's clear select is 0, each tick adds one to its counter. The counter wraps from 0xFF to 0x00.
- R4: A tick that finds the counter at 0xFF sets the channel's overflow flag. The overflow flag is bit 7 for the high channel and bit 3 for the low channel.
- R5: A tick that finds the counter equal to its compare value sets the channel's compare flag. The compare flag is bit 6 for the high channel and bit 2 for the low channel. A counter that only arrives at the compare value, without a tick while it is equal, sets no flag.
- R6: When a channel's clear select is 1, the tick that finds the counter equal to its compare value loads 0x00 into the counter instead of adding one. The clear select is bit 4 for the high channel and bit 0 for the low channel.
- R7: Writing 1 to a flag bit (bits 7, 6, 3 and 2) never sets that flag. The control bits (5, 4, 1, 0) read back exactly as they were written.
- R8: Writing 0 to a flag clears it only if a status read that returned that flag as 1 has happened since the flag's last clearing write. A write of 0 without such a read leaves the flag set.
- R9: After a status read has returned a flag as 1, writing 0 to that flag clears it. Writing 1 to that flag leaves it set.
- R10: If a hardware set and a clearing write hit the same flag in the same cycle, the flag stays 1. That clearing write still uses up the earlier read, so a later write of 0 needs a fresh read.
- R11: `irq_hi` is high exactly when bit 7 and bit 5 are both 1. `irq_lo` is high exactly when bit 3 and bit 1 are both 1.
- R12: The two channels count independently of each other. In a cycle where a bus write targets a counter, the written value wins over that counter's tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a status read arms the flag-clear handshake |
| bus_rdata | output | 8 | Read data of the addressed register |
| tick_hi | input | 1 | Count enable for the high channel |
| tick_lo | input | 1 | Count enable for the low channel |
| irq_hi | output | 1 | High-channel overflow interrupt |
| irq_lo | output | 1 | Low-channel overflow interrupt |

## Verification
The hardest case to reach is a hardware flag set that lands in the very cycle a clearing write arrives. To reach it, the bench loads the high counter with its compare value while the clear select is on. It then raises `tick_hi` and a status write of 0 on the same edge. The bench also has to show that this collision used up the earlier read. It does this by issuing a second zero-write before any new read and confirming the flag survives. Only after that does it read and clear the flag.

// File: rtl/dual_tmr8_pkg.sv
package dual_tmr8_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_LO  = 0;
  localparam int unsigned CH_HI  = 1;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned CSR_W  = NIB_W * NUM_CH;

  localparam logic [ADDR_W-1:0] A_CSR   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_H = 3'd2;
  localparam logic [ADDR_W-1:0] A_CNT_L = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_L = 3'd4;

  // per-channel nibble of the status byte, MSB first
  typedef struct packed {
    logic ovf;
    logic cmf;
    logic ovie;
    logic clr_sel;
  } ch_csr_t;
endpackage

// File: rtl/tmr8_flag.sv
module tmr8_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic rd_csr,
  input  logic wr_csr,
  input  logic wr_bit,
  output logic flag
);
  logic armed_q, armed_n, flag_n, clr_hit;

  always_comb begin
    clr_hit = wr_csr & ~wr_bit & armed_q;
    flag_n  = hw_set | (flag & ~clr_hit);
    if (clr_hit)
      armed_n = 1'b0;
    else if (rd_csr & flag)
      armed_n = 1'b1;
    else
      armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag    <= flag_n;
      armed_q <= armed_n;
    end
  end

  // R7: only hardware can raise a flag
  p_rise_by_hw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hw_set));

  // R8: a flag falls only after an armed zero-write
  p_fall_needs_arm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed_q && wr_csr && !wr_bit));

  // R10: hardware set beats a clearing write
  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set |=> flag);
endmodule

// File: rtl/tmr8_chan.sv
module tmr8_chan #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr_sel,
  input  logic             cnt_we,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp,
  output logic             ovf_evt,
  output logic             cmf_evt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             match;
  logic [CNT_W-1:0] cnt_n, cmp_n;

  always_comb begin
    match   = (cnt == cmp);
    cmf_evt = tick & match;
    ovf_evt = tick & (cnt == CNT_TOP);
    if (cnt_we)
      cnt_n = wdata;
    else if (tick)
      cnt_n = (clr_sel && match) ? '0 : cnt + ONE;
    else
      cnt_n = cnt;
    cmp_n = cmp_we ? wdata : cmp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      cmp <= '1;
    end else begin
      cnt <= cnt_n;
      cmp <= cmp_n;
    end
  end

  // R6: compare-clear mode restarts at zero
  p_clear_on_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && clr_sel && match) |=> (cnt == '0));

  // R3: free counting adds one per tick
  p_free_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_we && !(clr_sel && match)) |=> (cnt == $past(cnt) + ONE));

  // R12: a bus write overrides the tick
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (cnt == $past(wdata)));
endmodule

// File: rtl/dual_tmr8.sv
module dual_tmr8
  import dual_tmr8_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              tick_hi,
  input  logic              tick_lo,
  output logic              irq_hi,
  output logic              irq_lo
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic              csr_wr, csr_rd;
  logic [NUM_CH-1:0] tick_v, ovf_v, cmf_v, ovf_evt, cmf_evt;
  logic [NUM_CH-1:0] ovie_q, ovie_n, clrs_q, clrs_n;
  logic [NUM_CH-1:0] cnt_we, cmp_we, irq_v;
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CNT_W-1:0]  cmp_v [NUM_CH];
  logic [CSR_W-1:0]  csr;

  assign tick_v[CH_LO] = tick_lo;
  assign tick_v[CH_HI] = tick_hi;
  assign csr_wr = bus_wr & (bus_addr == A_CSR);
  assign csr_rd = bus_rd & (bus_addr == A_CSR);

  // control bits: next state
  always_comb begin
    ovie_n = ovie_q;
    clrs_n = clrs_q;
    if (csr_wr) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ovie_n[c] = bus_wdata[c*NIB_W + 1];
        clrs_n[c] = bus_wdata[c*NIB_W + 0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ovie_q <= '0;
      clrs_q <= '0;
    end else begin
      ovie_q <= ovie_n;
      clrs_q <= clrs_n;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_CNT = (ch == CH_HI) ? A_CNT_H : A_CNT_L;
    localparam logic [ADDR_W-1:0] A_CMP = (ch == CH_HI) ? A_CMP_H : A_CMP_L;
    ch_csr_t nib;

    assign cnt_we[ch] = bus_wr & (bus_addr == A_CNT);
    assign cmp_we[ch] = bus_wr & (bus_addr == A_CMP);

    tmr8_chan #(.CNT_W(CNT_W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .tick    (tick_v[ch]),
      .clr_sel (clrs_q[ch]),
      .cnt_we  (cnt_we[ch]),
      .cmp_we  (cmp_we[ch]),
      .wdata   (bus_wdata),
      .cnt     (cnt_v[ch]),
      .cmp     (cmp_v[ch]),
      .ovf_evt (ovf_evt[ch]),
      .cmf_evt (cmf_evt[ch])
    );

    tmr8_flag u_ovf (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .hw_set (ovf_evt[ch]),
      .rd_csr (csr_rd),
      .wr_csr (csr_wr),
      .wr_bit (bus_wdata[ch*NIB_W + 3]),
      .flag   (ovf_v[ch])
    );

    tmr8_flag u_cmf (
      .clk    (clk),
      .rst_n  (rst_n_s),
      .hw_set (cmf_evt[ch]),
      .rd_csr (csr_rd),
      .wr_csr (csr_wr),
      .wr_bit (bus_wdata[ch*NIB_W + 2]),
      .flag   (cmf_v[ch])
    );

    assign nib.ovf     = ovf_v[ch];
    assign nib.cmf     = cmf_v[ch];
    assign nib.ovie    = ovie_q[ch];
    assign nib.clr_sel = clrs_q[ch];
    assign csr[ch*NIB_W +: NIB_W] = nib;
    assign irq_v[ch]   = ovf_v[ch] & ovie_q[ch];
  end

  assign irq_hi = irq_v[CH_HI];
  assign irq_lo = irq_v[CH_LO];

  always_comb begin
    case (bus_addr)
      A_CSR:   bus_rdata = CNT_W'(csr);
      A_CNT_H: bus_rdata = cnt_v[CH_HI];
      A_CMP_H: bus_rdata = cmp_v[CH_HI];
      A_CNT_L: bus_rdata = cnt_v[CH_LO];
      A_CMP_L: bus_rdata = cmp_v[CH_LO];
      default: bus_rdata = '0;
    endcase
  end

  // R11: interrupt drops one cycle after an enable-off write
  p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    (csr_wr && !bus_wdata[CH_LO*NIB_W + 1]) |=> !irq_lo);
endmodule

// File: tb/dual_tmr8_tb.sv
module dual_tmr8_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic       bus_rd;
  logic [7:0] bus_rdata;
  logic       tick_hi, tick_lo, irq_hi, irq_lo;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  dual_tmr8 u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tick_hi(tick_hi), .tick_lo(tick_lo), .irq_hi(irq_hi), .irq_lo(irq_lo)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [1:0] op;   // 0 write, 1 read+check, 2 ticks high, 3 ticks low
    logic [2:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 3'd0, 8'h00, 8'h00},  // R1 status reset
    '{2'd1, 3'd1, 8'h00, 8'h00},  // R1 high counter
    '{2'd1, 3'd2, 8'h00, 8'hFF},  // R1 high compare
    '{2'd1, 3'd3, 8'h00, 8'h00},  // R1 low counter
    '{2'd1, 3'd4, 8'h00, 8'hFF},  // R1 low compare
    '{2'd0, 3'd2, 8'h05, 8'h00},  // R2 write high compare
    '{2'd1, 3'd2, 8'h00, 8'h05},
    '{2'd0, 3'd3, 8'hAA, 8'h00},  // R2 write low counter
    '{2'd1, 3'd3, 8'h00, 8'hAA},
    '{2'd0, 3'd0, 8'hFF, 8'h00},  // R7 ones to flag bits
    '{2'd1, 3'd0, 8'h00, 8'h33},
    '{2'd0, 3'd0, 8'h00, 8'h00},
    '{2'd1, 3'd0, 8'h00, 8'h00},
    '{2'd2, 3'd0, 8'd3,  8'h00},  // R3 three high ticks
    '{2'd1, 3'd1, 8'h00, 8'h03},
    '{2'd3, 3'd0, 8'd2,  8'h00},  // R12 low ticks only
    '{2'd1, 3'd3, 8'h00, 8'hAC},
    '{2'd1, 3'd1, 8'h00, 8'h03},
    '{2'd3, 3'd0, 8'd83, 8'h00},  // low reaches 0xFF
    '{2'd1, 3'd3, 8'h00, 8'hFF},
    '{2'd1, 3'd0, 8'h00, 8'h00},  // R5 arrival alone sets nothing
    '{2'd3, 3'd0, 8'd1,  8'h00},
    '{2'd1, 3'd3, 8'h00, 8'h00},  // R3 wrap
    '{2'd1, 3'd0, 8'h00, 8'h0C},  // R4 R5 low flags, read arms
    '{2'd0, 3'd0, 8'h00, 8'h00},
    '{2'd1, 3'd0, 8'h00, 8'h00}   // R9 cleared
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input bit hi, input int n);
    @(negedge clk);
    if (hi) tick_hi = 1'b1; else tick_lo = 1'b1;
    repeat (n) @(negedge clk);
    tick_hi = 1'b0; tick_lo = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    bus_rd = 1'b0; tick_hi = 1'b0; tick_lo = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 irq_hi", {7'd0, irq_hi}, 8'h00);
    check("R1 irq_lo", {7'd0, irq_lo}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: bus_write(VEC[i].addr, VEC[i].data);
        2'd1: bus_read($sformatf("table entry %0d", i), VEC[i].addr, VEC[i].exp);
        2'd2: ticks(1'b1, int'(VEC[i].data));
        default: ticks(1'b0, int'(VEC[i].data));
      endcase
    end

    // R11 / R8 / R9: low overflow with interrupt enabled
    bus_write(3'd0, 8'h02);
    bus_write(3'd3, 8'hFF);
    ticks(1'b0, 1);
    check("R11 irq_lo set", {7'd0, irq_lo}, 8'h01);
    check("R11 irq_hi idle", {7'd0, irq_hi}, 8'h00);
    bus_write(3'd0, 8'h02);             // zero-write with no read
    bus_read("R8 no read no clear", 3'd0, 8'h0E);
    bus_write(3'd0, 8'h0E);             // ones after read
    bus_read("R9 one-write keeps", 3'd0, 8'h0E);
    bus_write(3'd0, 8'h02);
    bus_read("R9 armed clear", 3'd0, 8'h02);
    check("R11 irq_lo cleared", {7'd0, irq_lo}, 8'h00);

    // R6: high channel compare-clear mode, compare 0x05, counter 0x03
    bus_write(3'd0, 8'h12);
    ticks(1'b1, 2);
    bus_read("R6 at compare", 3'd1, 8'h05);
    bus_read("R5 no flag yet", 3'd0, 8'h12);
    ticks(1'b1, 1);
    bus_read("R6 restart", 3'd1, 8'h00);
    bus_read("R5 high compare flag", 3'd0, 8'h52);
    bus_write(3'd0, 8'h12);
    bus_read("R9 high clear", 3'd0, 8'h12);

    // R10: set and clearing write collide
    bus_write(3'd1, 8'h05);
    ticks(1'b1, 1);
    bus_read("R10 setup", 3'd0, 8'h52);  // arms
    bus_write(3'd1, 8'h05);
    @(negedge clk);
    bus_addr = 3'd0; bus_wdata = 8'h12; bus_wr = 1'b1; tick_hi = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_hi = 1'b0;
    bus_write(3'd0, 8'h12);             // read was used up
    bus_read("R10 set wins, arm spent", 3'd0, 8'h52);
    bus_write(3'd0, 8'h12);
    bus_read("R10 later clear", 3'd0, 8'h12);

    // R12: write beats tick
    @(negedge clk);
    bus_addr = 3'd3; bus_wdata = 8'h40; bus_wr = 1'b1; tick_lo = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; tick_lo = 1'b0;
    bus_read("R12 write wins", 3'd3, 8'h40);

    // R4 / R3: low wrap without compare hit
    bus_write(3'd4, 8'h10);
    bus_write(3'd3, 8'hFE);
    ticks(1'b0, 2);
    bus_read("R3 wrap", 3'd3, 8'h00);
    bus_read("R4 low overflow", 3'd0, 8'h1A);

    // R1: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 irq_lo reset", {7'd0, irq_lo}, 8'h00);
    bus_addr = 3'd0; #1 check("R1 status reset", bus_rdata, 8'h00);
    bus_addr = 3'd1; #1 check("R1 counter reset", bus_rdata, 8'h00);
    bus_addr = 3'd4; #1 check("R1 compare reset", bus_rdata, 8'hFF);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end
endmodule